// File: doc/BRIEF.md
# Sequential Booth Radix-2 Multiplier

This block multiplies two `WIDTH`-bit operands over several clock cycles, one multiplier bit per cycle. It has two working registers: an accumulator that starts from zero and collects partial sums, and a multiplier register that is loaded with operand A. Each step adds to the accumulator, then shifts the two registers right as one pair. After `WIDTH` steps the accumulator holds the high half of the product and the multiplier register holds the low half.

A mode input, sampled with the start pulse, selects the arithmetic. In unsigned mode each step adds B or nothing, depending on the current low bit of the multiplier register. The carry out of that add shifts into the top of the accumulator. In two's-complement mode a saved copy of the bit shifted out last cycle goes with the current low bit, and the pair is Booth-recoded into add B, subtract B or add nothing. The shift then copies the true sign of the widened sum into the top bit.

The controller has three states. `ST_IDLE` waits for a start. `ST_RUN` performs one step per cycle. `ST_FINISH` lasts one cycle and raises done. The transitions are: IDLE→RUN on start; RUN→RUN while steps remain; RUN→FINISH on the last step; FINISH→RUN on start; FINISH→IDLE otherwise. IDLE stays in IDLE without a start.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A start seen in ST_IDLE or ST_FINISH latches `op_a`, `op_b` and `signed_mode`, and clears the accumulator. From the next cycle `busy` is 1, and `product` reads the cleared accumulator on top with `op_a` below it.
- R3: The block performs exactly `WIDTH` steps. `done` rises, and `busy` falls, `WIDTH` cycles after the cycle in which `busy` first reads 1.
- R4: With `signed_mode`=0, `product` equals the unsigned product of `op_a` and `op_b` over 2·`WIDTH` bits. No step ever subtracts.
- R5: With `signed_mode`=1, the step is chosen from the pair (current low bit, previous low bit). The codes are 00 or 11 add nothing, 01 add B and 10 subtract B. The previous bit is 0 on the first step. `product` equals the two's-complement product, for example -6 × -5 = +30 and -6 × +5 = -30.
- R6: Signed mode is exact at the range limits, including the most negative value times itself.
- R7: A start while `busy` is 1 is ignored. The running operation finishes with its own operands and its own step count.
- R8: After `done`, `product` holds its value until the next accepted start.
- R9: `done` is a one-cycle pulse and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when not busy |
| signed_mode | input | 1 | 1: two's-complement Booth; 0: unsigned shift-and-add |
| op_a | input | WIDTH | Multiplier operand |
| op_b | input | WIDTH | Multiplicand operand |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Accumulator (high half) and multiplier register (low half) |

## Verification
A start that arrives during a run is the hardest case to reach, because it is only meaningful in a narrow window. The stimulus lands that pulse a few cycles into a run, with different operands and the opposite mode, and then checks that the result and the step count belong to the first operation. The signed extremes do not turn up often under random stimulus. They are forced by directed operands: the most negative value times itself, times -1 and times the most positive value, together with the small worked examples.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } mult_state_t;

    typedef enum logic [1:0] {
        OP_ZERO = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } step_op_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_mult_pkg::*;
(
    input  logic     signed_mode,
    input  logic     cur_bit,
    input  logic     prev_bit,
    output step_op_t op
);
    always_comb begin
        if (signed_mode) begin
            unique case ({cur_bit, prev_bit})
                2'b01:   op = OP_ADD;
                2'b10:   op = OP_SUB;
                default: op = OP_ZERO;
            endcase
        end else begin
            op = cur_bit ? OP_ADD : OP_ZERO;
        end
    end

    // R4: unsigned steps only add
    always_comb begin
        if (signed_mode == 1'b0)
            assert_unsigned_no_sub_R4: assert (op != OP_SUB);
    end
endmodule

// File: rtl/booth_step_dp.sv
module booth_step_dp
    import booth_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mlr,
    input  logic [WIDTH-1:0] mcand,
    input  step_op_t         op,
    input  logic             signed_mode,
    output logic [WIDTH-1:0] acc_next,
    output logic [WIDTH-1:0] mlr_next
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] acc_ext;
    logic [EXT_W-1:0] mcand_ext;
    logic [EXT_W-1:0] sum;

    always_comb begin
        acc_ext   = {signed_mode & acc[WIDTH-1], acc};
        mcand_ext = {signed_mode & mcand[WIDTH-1], mcand};
        unique case (op)
            OP_ADD:  sum = acc_ext + mcand_ext;
            OP_SUB:  sum = acc_ext - mcand_ext;
            default: sum = acc_ext;
        endcase
        acc_next = sum[EXT_W-1:1];
        mlr_next = {sum[0], mlr[WIDTH-1:1]};
    end
endmodule

// File: rtl/booth_iter_counter.sv
module booth_iter_counter #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_VAL);

    // R3: the count advances by one each step until the last
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               signed_mode,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    mult_state_t      state_q, state_d;
    logic [WIDTH-1:0] acc_q, mlr_q, mcand_q;
    logic             prev_q, sgn_q;
    logic [WIDTH-1:0] acc_nx, mlr_nx;
    step_op_t         op;
    logic             accept, stepping, last_step;

    assign accept   = start && (state_q != ST_RUN);
    assign stepping = (state_q == ST_RUN);

    booth_recoder u_rec (
        .signed_mode (sgn_q),
        .cur_bit     (mlr_q[0]),
        .prev_bit    (prev_q),
        .op          (op)
    );

    booth_step_dp #(.WIDTH(WIDTH)) u_dp (
        .acc         (acc_q),
        .mlr         (mlr_q),
        .mcand       (mcand_q),
        .op          (op),
        .signed_mode (sgn_q),
        .acc_next    (acc_nx),
        .mlr_next    (mlr_nx)
    );

    booth_iter_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (stepping),
        .last  (last_step)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RUN;
            ST_RUN:    if (last_step) state_d = ST_FINISH;
            ST_FINISH: state_d = start ? ST_RUN : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_RUN);
        done = (state_q == ST_FINISH);
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mlr_q   <= '0;
            mcand_q <= '0;
            prev_q  <= 1'b0;
            sgn_q   <= 1'b0;
        end else if (accept) begin
            acc_q   <= '0;
            mlr_q   <= op_a;
            mcand_q <= op_b;
            prev_q  <= 1'b0;
            sgn_q   <= signed_mode;
        end else if (stepping) begin
            acc_q   <= acc_nx;
            mlr_q   <= mlr_nx;
            prev_q  <= mlr_q[0];
        end
    end

    assign product = {acc_q, mlr_q};

    // R9: done is a single-cycle pulse, never with busy
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    // R7: operands latched for a run do not change while busy
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mcand_q) && $stable(sgn_q)));
    // R8: product holds when no start is accepted outside a run
    assert_product_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
    // R2: an accepted start clears the accumulator
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && acc_q == '0));
    // R5: first signed step sees a zero previous bit
    assert_first_prev_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !prev_q);
endmodule

// File: tb/booth_seq_mult_test.sv
`timescale 1ns/1ps
module booth_seq_mult_test;
    localparam int W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             signed_mode = 1'b0;
    logic [W-1:0]     op_a = '0;
    logic [W-1:0]     op_b = '0;
    logic             busy, done;
    logic [2*W-1:0]   product;

    int checks = 0;
    int fails  = 0;
    int unsigned seed_v;

    always #2.5 clk = ~clk;

    booth_seq_mult #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*W-1:0] exp_prod(logic [W-1:0] a, logic [W-1:0] b, logic s);
        longint x, y;
        if (s) begin
            x = longint'($signed(a));
            y = longint'($signed(b));
        end else begin
            x = longint'(a);
            y = longint'(b);
        end
        return (2*W)'(x * y);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // one operation; intrude=1 pulses a foreign start mid-run
    task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic s, bit intrude, string req);
        int n;
        logic [2*W-1:0] hold;
        @(negedge clk);
        op_a = a; op_b = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy", busy, 1);
        check("R2 load", product, {{W{1'b0}}, a});
        n = 0;
        while (!done && n < W + 6) begin
            if (intrude && n == 2) begin
                op_a = ~a; op_b = b + 8'd3; signed_mode = ~s; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        check(intrude ? "R7 steps" : "R3 steps", n, W);
        check(req, product, exp_prod(a, b, s));
        check("R9 busy low at done", busy, 0);
        hold = product;
        @(negedge clk);
        check("R9 done pulse", done, 0);
        check("R8 hold", product, hold);
        @(negedge clk);
        check("R8 hold idle", product, hold);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++; checks++;
                $display("FAIL watchdog: actual %0d expected <150000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        seed_v = 32'd1234;
        void'($urandom(seed_v));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 product", product, 0);

        // directed worked examples, R5
        run_op(8'hFA, 8'hFB, 1'b1, 0, "R5 -6*-5");
        run_op(8'hFA, 8'h05, 1'b1, 0, "R5 -6*+5");
        // signed extremes, R6
        run_op(8'h80, 8'h80, 1'b1, 0, "R6 min*min");
        run_op(8'h80, 8'hFF, 1'b1, 0, "R6 min*-1");
        run_op(8'h7F, 8'h80, 1'b1, 0, "R6 max*min");
        run_op(8'h80, 8'h7F, 1'b1, 0, "R6 min*max");
        // unsigned corners, R4
        run_op(8'hFF, 8'hFF, 1'b0, 0, "R4 max*max");
        run_op(8'h00, 8'hA5, 1'b0, 0, "R4 zero");
        run_op(8'h80, 8'hFF, 1'b0, 0, "R4 msb");
        // intrusion, R7
        run_op(8'h5C, 8'h37, 1'b0, 1, "R7 unsigned");
        run_op(8'hC3, 8'h9E, 1'b1, 1, "R7 signed");

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] ra, rb;
            logic rs;
            ra = W'($urandom());
            rb = W'($urandom());
            rs = 1'($urandom());
            run_op(ra, rb, rs, (i % 17) == 5, rs ? "R5 random" : "R4 random");
        end

        // back-to-back start accepted in finish cycle
        @(negedge clk);
        op_a = 8'h0D; op_b = 8'h0B; signed_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W) @(negedge clk);
        check("R3 done b2b", done, 1);
        op_a = 8'hF3; op_b = 8'h07; signed_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 restart busy", busy, 1);
        repeat (W) @(negedge clk);
        check("R5 b2b product", product, exp_prod(8'hF3, 8'h07, 1'b1));

        finish_run();
    end
endmodule